// File: doc/BRIEF.md
# Flash Program/Erase Status Responder

This block models the status read path of a parallel NOR flash while an internal program or erase operation runs. A single-cycle strobe starts a word program (address plus data) or an erase (a sector-select mask, or a whole-chip flag). A sector protection mask comes in as a level input. The block holds a small word array in flops and keeps separate countdown counters for the program and erase operations. It also handles an erase-suspend state, and a word program may be issued while the erase is suspended.

Reads are combinational from `rd_addr`. An address that is valid for the running operation returns a status byte. Every other address returns the stored word. In the status byte, the top bit (bit 7 at the default width) is the polling bit. Two places below it (bit 5) is the fault flag. All other status bits read 0.

A program or erase aimed only at protected sectors runs a shorter fake-busy window and does not change the array. Every duration is a clock-cycle count set by a parameter.

Top module: `flash_stat_resp`

## Requirements
- R1: After reset every array word reads all-ones and `busy` is low.
- R2: A program strobe accepted while idle to an unprotected sector raises `busy` from the next cycle for exactly PROG_CYC cycles. During that time a read at the target address returns a status byte whose bit 7 is the complement of data bit 7, with the other bits 0 when no fault is injected. Afterwards the word holds the old value AND the new data.
- R3: A program strobe to a protected sector raises `busy` for exactly PROG_PROT_CYC cycles with the same complement status and leaves the array unchanged.
- R4: An erase strobe with a nonzero set of unprotected selected sectors raises `busy` for exactly ERASE_CYC cycles. During that time a read in any selected sector returns status with bit 7 = 0. Afterwards every word of each selected unprotected sector reads all-ones, and selected protected sectors keep their data.
- R5: An erase whose selected sectors are all protected raises `busy` for exactly ERASE_PROT_CYC cycles, reports bit 7 = 0 at selected addresses, and changes no word.
- R6: A chip erase treats every sector as selected. Any address in an unprotected sector is a valid status address, and all unprotected sectors are erased. If every sector is protected, it behaves as in R5 with all addresses valid.
- R7: A suspend strobe during an erase drops `busy` on the next cycle and freezes the erase count. Reads in the selected sectors then return status with bit 7 = 1. A resume strobe restarts the erase, which stays busy for exactly the cycles it had left.
- R8: A program strobe while suspended follows R2. It is treated as in R3 when its sector is protected or is one being erased. When it ends the block returns to suspend.
- R9: While `busy` is high, bit 5 of any status byte equals `fault_inj`. When not busy, `fault_inj` does not change any read.
- R10: Reads at addresses that are not status addresses return array data. Program and erase strobes that arrive while busy are ignored, and a program strobe takes priority over an erase strobe in the same idle cycle.
- R11: The address splits as {sector, word}: the top SECT_W bits select the sector, and sector mask bit s belongs to sector s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_go | input | 1 | Program start strobe |
| prog_addr | input | SECT_W+WORD_W | Program target address |
| prog_data | input | DW | Program data |
| erase_go | input | 1 | Erase start strobe |
| erase_chip | input | 1 | Erase all sectors |
| erase_sel | input | 2**SECT_W | Sector-select mask for erase |
| prot_mask | input | 2**SECT_W | Sector protection mask (1 = protected) |
| suspend_req | input | 1 | Erase suspend strobe |
| resume_req | input | 1 | Erase resume strobe |
| fault_inj | input | 1 | Injected fault flag, shown on bit 5 while busy |
| rd_addr | input | SECT_W+WORD_W | Read address |
| rd_data | output | DW | Status byte or array word |
| busy | output | 1 | An operation is running |

## Verification
A wrong counter value shows at the ports as a `busy` window that is too short or too long. This appears at the end of the operation, so the bench counts every busy cycle. A stray or missing array write shows up when all words are read after each operation completes. A wrong state or a wrong valid-sector mask flips the polling bit, or swaps status for array data, on the first read after the strobe. The bench therefore reads one valid address and one non-valid address in the cycle right after each start.

// File: rtl/flash_stat_resp.sv
module flash_stat_resp #(
  parameter int SECT_W         = 2,
  parameter int WORD_W         = 2,
  parameter int DW             = 8,
  parameter int PROG_CYC       = 12,
  parameter int PROG_PROT_CYC  = 4,
  parameter int ERASE_CYC      = 40,
  parameter int ERASE_PROT_CYC = 20
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     prog_go,
  input  logic [SECT_W+WORD_W-1:0] prog_addr,
  input  logic [DW-1:0]            prog_data,
  input  logic                     erase_go,
  input  logic                     erase_chip,
  input  logic [(1<<SECT_W)-1:0]   erase_sel,
  input  logic [(1<<SECT_W)-1:0]   prot_mask,
  input  logic                     suspend_req,
  input  logic                     resume_req,
  input  logic                     fault_inj,
  input  logic [SECT_W+WORD_W-1:0] rd_addr,
  output logic [DW-1:0]            rd_data,
  output logic                     busy
);

  localparam int AW    = SECT_W + WORD_W;
  localparam int NSECT = 1 << SECT_W;
  localparam int NWORD = 1 << AW;
  localparam int PMAX  = (PROG_CYC > PROG_PROT_CYC) ? PROG_CYC : PROG_PROT_CYC;
  localparam int EMAX  = (ERASE_CYC > ERASE_PROT_CYC) ? ERASE_CYC : ERASE_PROT_CYC;
  localparam int CMAX  = (PMAX > EMAX) ? PMAX : EMAX;
  localparam int CW    = $clog2(CMAX + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_PROG, S_PFAKE, S_ERASE, S_EFAKE, S_SUSP, S_SPROG, S_SPFAKE
  } st_t;

  st_t              st;
  logic [CW-1:0]    pcnt, ecnt;
  logic [AW-1:0]    paddr;
  logic [DW-1:0]    pdata;
  logic [NSECT-1:0] emask, vmask;
  logic [DW-1:0]    mem [NWORD];

  logic [SECT_W-1:0] psect, rsect;
  logic [NSECT-1:0]  eall, eeff;
  logic              pprot, prog_st, susp_st;

  assign psect   = prog_addr[AW-1:WORD_W];
  assign rsect   = rd_addr[AW-1:WORD_W];
  assign eall    = erase_chip ? '1 : erase_sel;
  assign eeff    = eall & ~prot_mask;
  assign pprot   = prot_mask[psect];
  assign prog_st = st inside {S_PROG, S_PFAKE, S_SPROG, S_SPFAKE};
  assign susp_st = st inside {S_SUSP, S_SPROG, S_SPFAKE};
  assign busy    = st inside {S_PROG, S_PFAKE, S_ERASE, S_EFAKE, S_SPROG, S_SPFAKE};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      pcnt  <= '0;
      ecnt  <= '0;
      paddr <= '0;
      pdata <= '0;
      emask <= '0;
      vmask <= '0;
      for (int w = 0; w < NWORD; w++) mem[w[AW-1:0]] <= '1;
    end else begin
      case (st)
        S_IDLE: begin
          if (prog_go) begin
            paddr <= prog_addr;
            pdata <= prog_data;
            pcnt  <= pprot ? CW'(PROG_PROT_CYC) : CW'(PROG_CYC);
            st    <= pprot ? S_PFAKE : S_PROG;
          end else if (erase_go && (erase_chip || |erase_sel)) begin
            emask <= eeff;
            vmask <= erase_chip ? ((|eeff) ? ~prot_mask : '1) : erase_sel;
            ecnt  <= (|eeff) ? CW'(ERASE_CYC) : CW'(ERASE_PROT_CYC);
            st    <= (|eeff) ? S_ERASE : S_EFAKE;
          end
        end
        S_PROG, S_SPROG: begin
          if (pcnt == CW'(1)) begin
            mem[paddr] <= mem[paddr] & pdata;
            st <= (st == S_SPROG) ? S_SUSP : S_IDLE;
          end else begin
            pcnt <= pcnt - CW'(1);
          end
        end
        S_PFAKE, S_SPFAKE: begin
          if (pcnt == CW'(1)) st <= (st == S_SPFAKE) ? S_SUSP : S_IDLE;
          else                pcnt <= pcnt - CW'(1);
        end
        S_ERASE: begin
          if (suspend_req) begin
            st <= S_SUSP;
          end else if (ecnt == CW'(1)) begin
            for (int w = 0; w < NWORD; w++)
              if (emask[w[AW-1:WORD_W]]) mem[w[AW-1:0]] <= '1;
            st <= S_IDLE;
          end else begin
            ecnt <= ecnt - CW'(1);
          end
        end
        S_EFAKE: begin
          if (ecnt == CW'(1)) st <= S_IDLE;
          else                ecnt <= ecnt - CW'(1);
        end
        S_SUSP: begin
          if (resume_req) begin
            st <= S_ERASE;
          end else if (prog_go) begin
            paddr <= prog_addr;
            pdata <= prog_data;
            pcnt  <= (pprot || emask[psect]) ? CW'(PROG_PROT_CYC) : CW'(PROG_CYC);
            st    <= (pprot || emask[psect]) ? S_SPFAKE : S_SPROG;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [DW-1:0] sbyte;
  always_comb begin
    sbyte = '0;
    sbyte[DW-3] = fault_inj & busy;
    rd_data = mem[rd_addr];
    if (prog_st && rd_addr == paddr) begin
      rd_data = sbyte;
      rd_data[DW-1] = ~pdata[DW-1];
    end else if (susp_st && vmask[rsect]) begin
      rd_data = sbyte;
      rd_data[DW-1] = 1'b1;
    end else if ((st == S_ERASE || st == S_EFAKE) && vmask[rsect]) begin
      rd_data = sbyte;
    end
  end

  p_prog_inv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PROG && rd_addr == paddr) |-> (rd_data[DW-1] != pdata[DW-1]));

  p_prog_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PROG && pcnt > CW'(1)) |=> (st == S_PROG && pcnt == $past(pcnt) - CW'(1)));

  p_erase_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ERASE && vmask[rsect]) |-> !rd_data[DW-1]);

  p_susp_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SUSP && vmask[rsect]) |-> (rd_data[DW-1] && !busy));

  p_susp_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SUSP) |=> $stable(ecnt));

  p_fault_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PROG && rd_addr == paddr) |-> (rd_data[DW-3] == fault_inj));

  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PROG && pcnt > CW'(1)) |=> $stable(paddr) && $stable(pdata));

endmodule

// File: tb/flash_stat_resp_test.sv
`timescale 1ns/1ps
module flash_stat_resp_test;
  localparam int PC = 5, PPC = 3, EC = 9, EPC = 6;

  logic clk = 0, rst_n = 0;
  logic prog_go = 0, erase_go = 0, erase_chip = 0, suspend_req = 0, resume_req = 0, fault_inj = 0;
  logic [3:0] prog_addr = 0, rd_addr = 0, erase_sel = 0, prot_mask = 0;
  logic [7:0] prog_data = 0, rd_data;
  logic busy;

  int checks = 0, errors = 0;
  logic [7:0] mdl [16];

  always #2.5 clk = ~clk;

  flash_stat_resp #(.SECT_W(2), .WORD_W(2), .DW(8), .PROG_CYC(PC), .PROG_PROT_CYC(PPC),
    .ERASE_CYC(EC), .ERASE_PROT_CYC(EPC)) uut (
    .clk(clk), .rst_n(rst_n), .prog_go(prog_go), .prog_addr(prog_addr), .prog_data(prog_data),
    .erase_go(erase_go), .erase_chip(erase_chip), .erase_sel(erase_sel), .prot_mask(prot_mask),
    .suspend_req(suspend_req), .resume_req(resume_req), .fault_inj(fault_inj),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] stat(input logic b7, input logic f);
    return {b7, 1'b0, f, 5'b0};
  endfunction

  task automatic sweep(input string req);
    for (int a = 0; a < 16; a++) begin
      rd_addr = a[3:0];
      #1;
      chk(req, rd_data, mdl[a]);
    end
  endtask

  task automatic count_busy(input string req, input int exp);
    int n = 0;
    while (busy && n < 200) begin
      n++;
      @(negedge clk); #1;
    end
    chk(req, n, exp);
  endtask

  task automatic do_prog(input logic [3:0] a, input logic [7:0] d, input logic fake,
                         input logic sw, input string req);
    @(negedge clk);
    prog_go = 1; prog_addr = a; prog_data = d;
    @(negedge clk);
    prog_go = 0;
    rd_addr = a;
    #1;
    chk(req, rd_data, stat(~d[7], fault_inj));
    count_busy(req, fake ? PPC : PC);
    if (!fake) mdl[a] = mdl[a] & d;
    if (sw) sweep(req);
  endtask

  task automatic do_erase(input logic [3:0] sel, input logic chip, input string req);
    logic [3:0] all, eff, vm;
    int vs, ns;
    all = chip ? 4'hF : sel;
    eff = all & ~prot_mask;
    vm  = chip ? ((eff != 0) ? ~prot_mask : 4'hF) : sel;
    vs = -1; ns = -1;
    for (int s = 0; s < 4; s++) begin
      if (vm[s] && vs < 0) vs = s;
      if (!vm[s] && ns < 0) ns = s;
    end
    @(negedge clk);
    erase_go = 1; erase_sel = sel; erase_chip = chip;
    @(negedge clk);
    erase_go = 0; erase_chip = 0;
    if (vs >= 0) begin
      rd_addr = {vs[1:0], 2'b01};
      #1;
      chk(req, rd_data, 8'h00);
    end
    if (ns >= 0) begin
      rd_addr = {ns[1:0], 2'b10};
      #1;
      chk({req, " R10"}, rd_data, mdl[{ns[1:0], 2'b10}]);
    end
    #1;
    count_busy(req, (eff != 0) ? EC : EPC);
    for (int w = 0; w < 16; w++) if (eff[w >> 2]) mdl[w] = 8'hFF;
    sweep(req);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=finished", checks);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int a = 0; a < 16; a++) mdl[a] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 busy", busy, 0);
    sweep("R1");

    // R2 R3 R9 R11: program sweep, sector 2 protected
    prot_mask = 4'b0100;
    for (int a = 0; a < 16; a++) begin
      fault_inj = (a == 5);
      do_prog(a[3:0], 8'((a * 37 + 5) & 8'hFF), prot_mask[a >> 2], 1, (a >> 2) == 2 ? "R3" : "R2 R9 R11");
    end
    fault_inj = 0;
    for (int a = 0; a < 16; a++)
      do_prog(a[3:0], ~8'(a * 11), prot_mask[a >> 2], 1, (a >> 2) == 2 ? "R3" : "R2");

    // R9: fault flag ignored while idle
    fault_inj = 1; rd_addr = 4'd7; #1;
    chk("R9 idle", rd_data, mdl[7]);
    fault_inj = 0;

    // R4 R5: erase sweep over select masks
    for (int s = 1; s < 16; s++) begin
      int pa = (s * 5) & 15;
      if (!prot_mask[pa >> 2]) do_prog(pa[3:0], 8'h3C, 0, 0, "R2");
      do_erase(s[3:0], 0, (s == 4) ? "R5" : "R4");
    end

    // R6: chip erase, partial and full protection
    do_prog(4'd3, 8'h11, 0, 0, "R2");
    do_prog(4'd5, 8'h22, 0, 0, "R2");
    prot_mask = 4'b1010;
    do_erase(4'b0000, 1, "R6");
    do_prog(4'd0, 8'h44, 0, 0, "R2");
    prot_mask = 4'b1111;
    do_erase(4'b0000, 1, "R6 R5");

    // R10: strobes during busy ignored
    prot_mask = 4'b0000;
    @(negedge clk); prog_go = 1; prog_addr = 4'd1; prog_data = 8'h0F;
    @(negedge clk); prog_go = 0;
    @(negedge clk); prog_go = 1; prog_addr = 4'd2; prog_data = 8'h00;
    erase_go = 1; erase_chip = 1;
    @(negedge clk); prog_go = 0; erase_go = 0; erase_chip = 0; #1;
    count_busy("R10", PC - 2);
    mdl[1] = mdl[1] & 8'h0F;
    sweep("R10");

    // R10: program beats erase in the same cycle
    @(negedge clk); prog_go = 1; prog_addr = 4'd9; prog_data = 8'h70;
    erase_go = 1; erase_sel = 4'b0010;
    @(negedge clk); prog_go = 0; erase_go = 0; #1;
    count_busy("R10 prio", PC);
    mdl[9] = mdl[9] & 8'h70;
    sweep("R10 prio");

    // R7 R8: suspend / program in suspend / resume
    prot_mask = 4'b0001;
    do_prog(4'd4, 8'h00, 0, 0, "R2");
    do_prog(4'd5, 8'h81, 0, 0, "R2");
    @(negedge clk); erase_go = 1; erase_sel = 4'b0010;
    @(negedge clk); erase_go = 0; rd_addr = 4'd4; #1;
    chk("R4 start", rd_data, 8'h00);
    for (int i = 0; i < 3; i++) begin
      chk("R7 run", busy, 1);
      @(negedge clk);
    end
    suspend_req = 1;
    @(negedge clk); suspend_req = 0; #1;
    chk("R7 busy", busy, 0);
    rd_addr = 4'd4; #1;
    chk("R7 status", rd_data, 8'h80);
    rd_addr = 4'd8; #1;
    chk("R7 other", rd_data, mdl[8]);
    do_prog(4'd12, 8'h5A, 0, 0, "R8");
    rd_addr = 4'd5; #1;
    chk("R8 back", rd_data, 8'h80);
    chk("R8 idle", busy, 0);
    do_prog(4'd1, 8'h00, 1, 0, "R8 prot");
    rd_addr = 4'd1; #1;
    chk("R8 prot", rd_data, mdl[1]);
    do_prog(4'd6, 8'h00, 1, 0, "R8 erasing");
    rd_addr = 4'd12; #1;
    chk("R8 data", rd_data, mdl[12]);
    @(negedge clk); resume_req = 1;
    @(negedge clk); resume_req = 0; #1;
    count_busy("R7 resume", EC - 3);
    for (int w = 4; w < 8; w++) mdl[w] = 8'hFF;
    sweep("R7");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule